// File: doc/BRIEF.md
# DDR SDRAM Command Timing Gate

This block sits between a memory controller's request queue and the command bus of a four-bank DDR SDRAM. One request is offered at a time through a valid/ready handshake. Each request carries a command code, a bank number, an address and an auto-precharge flag. The address is a row for a row activation and a column for a read or write. The gate issues the request on the command bus only when every timing rule allows it. In every other cycle the bus carries a NOP.

Each bank is tracked by its own state machine. Its states are `BK_IDLE` (row closed), `BK_ACTIVE` (row open), `BK_APWAIT` (a column command with auto precharge was issued, and the bank waits for the burst to end and for the minimum row-active time) and `BK_PRECHG` (precharge in progress). The transitions are as follows:
- `BK_IDLE` goes to `BK_ACTIVE` on an issued activation.
- `BK_ACTIVE` goes to `BK_PRECHG` on an issued explicit precharge.
- `BK_ACTIVE` goes to `BK_APWAIT` on an issued read or write with auto precharge.
- `BK_APWAIT` goes to `BK_PRECHG` once both the burst counter and the row-active counter reach zero.
- `BK_PRECHG` goes to `BK_IDLE` when its precharge counter reaches zero.
- `BK_PRECHG` goes straight to `BK_ACTIVE` if an activation is issued in that same final cycle.

One timer is shared by all banks and spaces activations apart. The timing values are runtime inputs in cycles, valid from 1 to 15.

Top module: `ddr_act_sched`

## Requirements
- R1: After an activation is handshaken in cycle t, no other activation to any bank is handshaken before cycle t + cfg_trrd. With no other obstacle, the next activation is accepted exactly in cycle t + cfg_trrd.
- R2: A read or write to a bank is accepted no earlier than cfg_trcd cycles after the activation of that bank.
- R3: Column commands to an open bank whose activation delay has elapsed are accepted in consecutive cycles, with no gap between them.
- R4: An explicit precharge (code 4) to an open bank is accepted no earlier than cfg_tras cycles after that bank's activation. A new activation of the bank is accepted cfg_trp cycles after the precharge.
- R5: A read or write with req_autopre set starts a precharge in cycle m = max(c + BURST_CYC, a + cfg_tras), where c is the column command's cycle and a is the activation's cycle. The bank accepts a new activation in cycle m + cfg_trp.
- R6: A read or write to a bank that is not in `BK_ACTIVE` is rejected, and so is a reserved command code (5 to 7). A rejected request is accepted at once, the bus stays NOP, and err_pulse is high for exactly the next cycle.
- R7: While the offered request violates a timing counter, req_ready is low and cmd_out stays NOP.
- R8: After reset, cmd_out is NOP (0), err_pulse is 0, and an activation to any bank is ready at once.
- R9: An activation to a bank whose row is open (`BK_ACTIVE`) is rejected as in R6.
- R10: A precharge to a bank that is not open, or a NOP request (code 0), is accepted with no effect: the bus stays NOP and err_pulse stays low.
- R11: An issued command appears on cmd_out, cmd_bank, cmd_addr and cmd_autopre in the cycle after its handshake. The codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 4 | Cycles from activation to a column command in the same bank |
| cfg_trrd | input | 4 | Cycles between activations of any banks |
| cfg_tras | input | 4 | Minimum cycles from activation to the start of precharge |
| cfg_trp | input | 4 | Precharge duration in cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 3 | Request command code |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Row address (activation) or column address (read or write) |
| req_autopre | input | 1 | Auto precharge after a read or write |
| cmd_out | output | 3 | Command on the memory bus |
| cmd_bank | output | 2 | Bank of the bus command |
| cmd_addr | output | 13 | Address of the bus command |
| cmd_autopre | output | 1 | Auto-precharge flag of the bus command |
| err_pulse | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions check the following on every cycle:
- No activation is issued while the shared spacing timer is running.
- No column command reaches a bank that is not open or whose activation delay is still counting.
- No precharge starts before the row-active time has elapsed.
- A bank waiting for auto precharge stays in `BK_APWAIT` while the row-active counter is nonzero.
- A stall or a rejection leaves a NOP on the bus.

Only the bench scenarios can show the exact acceptance cycles, because those depend on the configured values:
- activation-to-activation spacing
- activation-to-column delay
- precharge-to-activation delay
- the max() rule for auto precharge
- the output fields of each issued command
- the silent handling of requests that have no effect

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_APWAIT,
        BK_PRECHG
    } bank_st_e;

    typedef enum logic [1:0] {
        DEC_STALL,
        DEC_ISSUE,
        DEC_REJECT,
        DEC_DROP
    } decision_e;

endpackage

// File: rtl/ddr_rrd_timer.sv
module ddr_rrd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_trrd,
    input  logic             act_go,
    output logic             rrd_ok
);

    logic [CNT_W-1:0] rrd_cnt;
    logic [CNT_W-1:0] rrd_load;

    // cnt holds (cfg-1) after the activation, so it reaches zero cfg cycles later
    assign rrd_load = (cfg_trrd == '0) ? '0 : cfg_trrd - CNT_W'(1);
    assign rrd_ok   = (rrd_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_cnt <= '0;
        end else if (act_go) begin
            rrd_cnt <= rrd_load;
        end else if (rrd_cnt != '0) begin
            rrd_cnt <= rrd_cnt - CNT_W'(1);
        end
    end

    AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (rrd_cnt == '0)); // R1

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
    import ddr_sched_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BURST_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_trcd,
    input  logic [CNT_W-1:0] cfg_tras,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic             act_go,
    input  logic             col_go,
    input  logic             col_ap,
    input  logic             pre_go,
    output bank_st_e         bank_st,
    output logic             act_ok,
    output logic             col_ok,
    output logic             pre_ok
);

    localparam int BC_W  = $clog2(BURST_CYC + 1);
    localparam int AUX_W = (BC_W > CNT_W) ? BC_W : CNT_W;

    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] rcd_cnt;
    logic [CNT_W-1:0] ras_cnt;
    logic [AUX_W-1:0] aux_cnt;
    logic             pre_start;
    logic             ap_start;

    function automatic logic [CNT_W-1:0] cyc_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    assign ap_start  = (st_q == BK_ACTIVE) && col_go && col_ap;
    assign pre_start = ((st_q == BK_ACTIVE) && pre_go) ||
                       ((st_q == BK_APWAIT) && (aux_cnt == '0) && (ras_cnt == '0));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_go) st_d = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (pre_go)        st_d = BK_PRECHG;
                else if (ap_start) st_d = BK_APWAIT;
            end
            BK_APWAIT: begin
                if (pre_start) st_d = BK_PRECHG;
            end
            BK_PRECHG: begin
                if (act_go)                st_d = BK_ACTIVE;
                else if (aux_cnt == '0)    st_d = BK_IDLE;
            end
        endcase
    end

    // timing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            ras_cnt <= '0;
            aux_cnt <= '0;
        end else begin
            if (act_go)               rcd_cnt <= cyc_load(cfg_trcd);
            else if (rcd_cnt != '0)   rcd_cnt <= rcd_cnt - CNT_W'(1);

            if (act_go)               ras_cnt <= cyc_load(cfg_tras);
            else if (ras_cnt != '0)   ras_cnt <= ras_cnt - CNT_W'(1);

            if (pre_start)            aux_cnt <= AUX_W'(cyc_load(cfg_trp));
            else if (ap_start)        aux_cnt <= AUX_W'(BURST_CYC - 1);
            else if (aux_cnt != '0)   aux_cnt <= aux_cnt - AUX_W'(1);
        end
    end

    // outputs
    always_comb begin
        bank_st = st_q;
        act_ok  = (st_q == BK_IDLE) || ((st_q == BK_PRECHG) && (aux_cnt == '0));
        col_ok  = (st_q == BK_ACTIVE) && (rcd_cnt == '0);
        pre_ok  = (st_q == BK_ACTIVE) && (ras_cnt == '0);
    end

    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        col_go |-> ((st_q == BK_ACTIVE) && (rcd_cnt == '0))); // R2

    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |-> (ras_cnt == '0)); // R4

    AST_AP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == BK_APWAIT) && (ras_cnt != '0)) |=> (st_q == BK_APWAIT)); // R5

    AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> ((st_q == BK_IDLE) || (st_q == BK_PRECHG))); // R9

endmodule

// File: rtl/ddr_act_sched.sv
module ddr_act_sched
    import ddr_sched_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int ADDR_W    = 13,
    parameter int CNT_W     = 4,
    parameter int BURST_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_trcd,
    input  logic [CNT_W-1:0]  cfg_trrd,
    input  logic [CNT_W-1:0]  cfg_tras,
    input  logic [CNT_W-1:0]  cfg_trp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_autopre,
    output logic [2:0]        cmd_out,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_autopre,
    output logic              err_pulse
);

    bank_st_e              bk_st  [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bk_act_ok;
    logic [NUM_BANKS-1:0]  bk_col_ok;
    logic [NUM_BANKS-1:0]  bk_pre_ok;
    logic [NUM_BANKS-1:0]  bk_act_go;
    logic [NUM_BANKS-1:0]  bk_col_go;
    logic [NUM_BANKS-1:0]  bk_pre_go;
    logic                  rrd_ok;
    logic                  any_act;
    decision_e             dec;
    logic                  fire;
    logic                  issue;
    bank_st_e              head_st;

    assign head_st = bk_st[req_bank];

    // decision on the head request
    always_comb begin
        dec = DEC_DROP;
        unique case (req_cmd)
            CMD_NOP: dec = DEC_DROP;
            CMD_ACT: begin
                if (head_st == BK_ACTIVE)                 dec = DEC_REJECT;
                else if (bk_act_ok[req_bank] && rrd_ok)   dec = DEC_ISSUE;
                else                                      dec = DEC_STALL;
            end
            CMD_RD, CMD_WR: begin
                if (head_st != BK_ACTIVE)                 dec = DEC_REJECT;
                else if (bk_col_ok[req_bank])             dec = DEC_ISSUE;
                else                                      dec = DEC_STALL;
            end
            CMD_PRE: begin
                if (head_st != BK_ACTIVE)                 dec = DEC_DROP;
                else if (bk_pre_ok[req_bank])             dec = DEC_ISSUE;
                else                                      dec = DEC_STALL;
            end
            default: dec = DEC_REJECT;
        endcase
    end

    assign req_ready = (dec != DEC_STALL);
    assign fire      = req_valid && req_ready;
    assign issue     = fire && (dec == DEC_ISSUE);
    assign any_act   = issue && (req_cmd == CMD_ACT);

    ddr_rrd_timer #(.CNT_W(CNT_W)) u_rrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_trrd (cfg_trrd),
        .act_go   (any_act),
        .rrd_ok   (rrd_ok)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic sel;
        assign sel           = issue && (req_bank == BANK_W'(gi));
        assign bk_act_go[gi] = sel && (req_cmd == CMD_ACT);
        assign bk_col_go[gi] = sel && ((req_cmd == CMD_RD) || (req_cmd == CMD_WR));
        assign bk_pre_go[gi] = sel && (req_cmd == CMD_PRE);

        ddr_bank_fsm #(.CNT_W(CNT_W), .BURST_CYC(BURST_CYC)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_trcd (cfg_trcd),
            .cfg_tras (cfg_tras),
            .cfg_trp  (cfg_trp),
            .act_go   (bk_act_go[gi]),
            .col_go   (bk_col_go[gi]),
            .col_ap   (req_autopre),
            .pre_go   (bk_pre_go[gi]),
            .bank_st  (bk_st[gi]),
            .act_ok   (bk_act_ok[gi]),
            .col_ok   (bk_col_ok[gi]),
            .pre_ok   (bk_pre_ok[gi])
        );
    end

    // registered command bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_out     <= CMD_NOP;
            cmd_bank    <= '0;
            cmd_addr    <= '0;
            cmd_autopre <= 1'b0;
            err_pulse   <= 1'b0;
        end else begin
            cmd_out     <= issue ? req_cmd : CMD_NOP;
            cmd_bank    <= issue ? req_bank : '0;
            cmd_addr    <= issue ? req_addr : '0;
            cmd_autopre <= issue && req_autopre &&
                           ((req_cmd == CMD_RD) || (req_cmd == CMD_WR));
            err_pulse   <= fire && (dec == DEC_REJECT);
        end
    end

    AST_ERR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (cmd_out == CMD_NOP)); // R6

    AST_STALL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (cmd_out == CMD_NOP)); // R7

endmodule

// File: tb/ddr_act_sched_tb.sv
module ddr_act_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_trcd = 4'd4;
    logic [3:0]  cfg_trrd = 4'd3;
    logic [3:0]  cfg_tras = 4'd7;
    logic [3:0]  cfg_trp  = 4'd3;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_addr = 13'd0;
    logic        req_autopre = 1'b0;
    logic [2:0]  cmd_out;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        cmd_autopre;
    logic        err_pulse;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit stall_bad;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_act_sched u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_trcd(cfg_trcd), .cfg_trrd(cfg_trrd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_addr(req_addr), .req_autopre(req_autopre),
        .cmd_out(cmd_out), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_autopre(cmd_autopre), .err_pulse(err_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // offer a request from a negedge until accepted; returns at the negedge after
    // the accepting edge, where the registered outputs show the result
    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a,
                         input logic ap, output int acc, output int waits);
        req_cmd = c; req_bank = b; req_addr = a; req_autopre = ap; req_valid = 1'b1;
        waits = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            waits++;
            if (cmd_out != 3'd0) stall_bad = 1'b1;
        end
        acc = cyc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(cmd_out == 3'd0, "R8 cmd after reset", cmd_out, 0);
        chk(err_pulse == 1'b0, "R8 err after reset", err_pulse, 0);
        req_cmd = 3'd1; req_bank = 2'd3; #1;
        chk(req_ready == 1'b1, "R8 act ready after reset", req_ready, 1);
    endtask

    task automatic t_rrd();
        int a0, a1, w;
        do_reset();
        stall_bad = 1'b0;
        issue(3'd1, 2'd0, 13'h123, 1'b0, a0, w);
        chk(cmd_out == 3'd1 && cmd_bank == 2'd0 && cmd_addr == 13'h123,
            "R11 act fields", cmd_addr, 13'h123);
        issue(3'd1, 2'd1, 13'h045, 1'b0, a1, w);
        chk(a1 - a0 == 3, "R1 act-act spacing", a1 - a0, 3);
        chk(w == 2, "R7 ready low during spacing", w, 2);
        chk(!stall_bad, "R7 nop while stalled", stall_bad, 0);
    endtask

    task automatic t_rcd();
        int a, r, r2, w2, w;
        do_reset();
        issue(3'd1, 2'd2, 13'h077, 1'b0, a, w);
        issue(3'd2, 2'd2, 13'h010, 1'b0, r, w);
        chk(r - a == 4, "R2 act-col delay", r - a, 4);
        chk(cmd_out == 3'd2 && cmd_bank == 2'd2 && cmd_addr == 13'h010 && !cmd_autopre,
            "R11 read fields", cmd_out, 2);
        issue(3'd3, 2'd2, 13'h011, 1'b0, w2, w);
        chk(w2 - r == 1 && cmd_out == 3'd3, "R3 back-to-back write", w2 - r, 1);
        issue(3'd2, 2'd2, 13'h012, 1'b0, r2, w);
        chk(r2 - w2 == 1 && cmd_addr == 13'h012, "R3 back-to-back read", r2 - w2, 1);
    endtask

    task automatic t_pre();
        int a, p, q, w;
        do_reset();
        issue(3'd1, 2'd0, 13'h001, 1'b0, a, w);
        issue(3'd4, 2'd0, 13'h000, 1'b0, p, w);
        chk(p - a == 7, "R4 act-pre spacing", p - a, 7);
        chk(cmd_out == 3'd4 && cmd_bank == 2'd0, "R11 pre fields", cmd_out, 4);
        issue(3'd1, 2'd0, 13'h002, 1'b0, q, w);
        chk(q - p == 3, "R4 pre-act delay", q - p, 3);
    endtask

    task automatic t_autopre();
        int a, r, q, w;
        do_reset();
        issue(3'd1, 2'd1, 13'h0AA, 1'b0, a, w);
        issue(3'd2, 2'd1, 13'h020, 1'b1, r, w);
        chk(cmd_autopre == 1'b1, "R11 autopre flag", cmd_autopre, 1);
        issue(3'd1, 2'd1, 13'h0AB, 1'b0, q, w);
        chk(q - a == 10, "R5 ras-bound auto precharge", q - a, 10);
        cfg_tras = 4'd2;
        do_reset();
        issue(3'd1, 2'd3, 13'h0CC, 1'b0, a, w);
        issue(3'd3, 2'd3, 13'h030, 1'b1, r, w);
        issue(3'd1, 2'd3, 13'h0CD, 1'b0, q, w);
        chk(q - a == 9, "R5 burst-bound auto precharge", q - a, 9);
        cfg_tras = 4'd7;
    endtask

    task automatic t_reject();
        int a, x, w;
        do_reset();
        issue(3'd2, 2'd3, 13'h005, 1'b0, x, w);
        chk(w == 0 && err_pulse && cmd_out == 3'd0, "R6 col to closed bank", err_pulse, 1);
        @(negedge clk);
        chk(err_pulse == 1'b0, "R6 error lasts one cycle", err_pulse, 0);
        issue(3'd1, 2'd0, 13'h009, 1'b0, a, w);
        issue(3'd1, 2'd0, 13'h00A, 1'b0, x, w);
        chk(x - a == 1 && err_pulse && cmd_out == 3'd0, "R9 act to open bank", err_pulse, 1);
        issue(3'd4, 2'd2, 13'h000, 1'b0, x, w);
        chk(w == 0 && !err_pulse && cmd_out == 3'd0, "R10 pre to closed bank", cmd_out, 0);
        issue(3'd0, 2'd0, 13'h000, 1'b0, x, w);
        chk(!err_pulse && cmd_out == 3'd0, "R10 nop request", err_pulse, 0);
        issue(3'd6, 2'd1, 13'h000, 1'b0, x, w);
        chk(err_pulse && cmd_out == 3'd0, "R6 reserved code", err_pulse, 1);
        // bank 0 must still be open: a read after its delay is issued
        issue(3'd2, 2'd0, 13'h040, 1'b0, x, w);
        chk(cmd_out == 3'd2 && !err_pulse, "R10 open row kept", cmd_out, 2);
    endtask

    initial begin
        t_reset();
        t_rrd();
        t_rcd();
        t_pre();
        t_autopre();
        t_reject();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule